// File: doc/BRIEF.md
# Three-Level Priority Interrupt Arbiter

This block arbitrates eight interrupt sources for a small CPU whose machine cycle is four clocks long. In every machine cycle it looks at the request flags of that cycle, gates each flag with its enable bits and sorts the eligible ones into three levels. It then decides whether the CPU must start a hardware vector call. When it issues a call, it gives the 16-bit vector address and a one-hot acknowledge for the chosen source. It also gives a clear strobe for the flags that the hardware clears on entry, and it records that the chosen level is now in service.

The power-fail source always sits on a top level of its own and needs only its own enable bit. Each of the other seven sources can be placed on the high or the low level, and those sources also need the global enable. A request is not stored. A request that is refused in one poll and has dropped by the next poll is lost. The CPU supplies three status strobes: the last machine cycle of the instruction, a write to an enable or priority register, and a return-from-interrupt. A return-from-interrupt ends the highest level that is in service.

Top module: `intc_prio_arb`

## Requirements
- R1: While rst_ni is low and after it is released, call_o, ack_o, clr_o, vec_o and in_svc_o are all zero until the first call.
- R2: The block polls once per machine cycle, on every fourth rising edge after reset release. A call appears as call_o high for exactly one clock right after that edge, together with a one-hot ack_o.
- R3: Source 0 (power-fail) is eligible when req_i[0] and en_i[0] are both set, whatever glb_en_i is. Sources 1 to 7 also need glb_en_i.
- R4: Source 0 is on the top level. Source s (1 to 7) is on the high level if hi_pri_i[s] is set and on the low level otherwise, and hi_pri_i[0] is ignored. The highest level wins. Within a level, the lowest source index wins.
- R5: The vectors are 0033h for source 0, 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh for sources 1 to 6, and 0063h for source 7.
- R6: A call is issued only in a poll where last_cyc_i=1, reg_wr_i=0 and reti_i=0.
- R7: No call is issued for a winner whose level, or any level above it, is in service.
- R8: A request that is refused at one poll and inactive at the next poll is never serviced.
- R9: The request of source 5 is req_i[5] OR ser_tx_i. The request of source 6 is req_i[6] OR t2_ext_i.
- R10: After a call, the next three polls issue no call, because the hardware call lasts four machine cycles.
- R11: in_svc_o[2], [1] and [0] mark the top, high and low levels in service. A call sets the bit of its level. A poll with reti_i=1 clears the highest bit that is set.
- R12: With a call, clr_o always has bit 2 or bit 4 set when source 2 or 4 is acknowledged. It has bit 1 or bit 3 set for source 1 or 3 only when ext_edge_i[0] or ext_edge_i[1] respectively is set. Bits 0, 5, 6 and 7 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request flags, bit index = source number |
| ser_tx_i | input | 1 | Second serial flag, ORed into source 5 |
| t2_ext_i | input | 1 | Second timer-2 flag, ORed into source 6 |
| en_i | input | 8 | Per-source enable |
| glb_en_i | input | 1 | Global enable for sources 1 to 7 |
| hi_pri_i | input | 8 | High-level select for sources 1 to 7 (bit 0 unused) |
| ext_edge_i | input | 2 | Edge mode of sources 1 and 3 |
| last_cyc_i | input | 1 | Current machine cycle ends the instruction |
| reg_wr_i | input | 1 | Instruction writes an enable or priority register |
| reti_i | input | 1 | Return-from-interrupt executed |
| call_o | output | 1 | One-clock vector call strobe |
| ack_o | output | 8 | One-hot acknowledge of the chosen source |
| vec_o | output | 16 | Vector address of the last call |
| clr_o | output | 8 | Flag clear strobe |
| in_svc_o | output | 3 | Levels in service (2 top, 1 high, 0 low) |

## Verification
Every result is registered, so it appears one clock after the poll edge that the stimulus reached. The poll edge is every fourth rising edge after reset. The bench holds each stimulus for exactly one machine cycle, starting at a falling edge, so each window contains exactly one poll. It reads the outputs one nanosecond after the window's fourth falling edge, and a monitor records every call at falling edges. The monitor also checks that each call follows a poll edge, which is a posedge count that is a multiple of four. The busy window is checked by counting the polls that follow a call, and in-service changes are read in the window after each return.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC = 8;
  localparam int NLVL = 3;
  localparam int IDXW = $clog2(NSRC);

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_TOP  = 2'd2
  } lvl_e;

  // vector spacing is uneven: top source and watchdog sit apart
  function automatic logic [15:0] vec_of(input logic [IDXW-1:0] idx);
    case (idx)
      3'd0:    vec_of = 16'h0033;
      3'd7:    vec_of = 16'h0063;
      default: vec_of = 16'h0003 + {10'd0, idx - 3'd1, 3'd0};
    endcase
  endfunction
endpackage

// File: rtl/intc_phase.sv
module intc_phase #(
  parameter int PHASES  = 4,
  parameter int CALL_MC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic call_i,
  output logic poll_o,
  output logic poll_ok_o
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int BW = $clog2(CALL_MC) + 1;

  logic [PW-1:0] phase_q;
  logic [BW-1:0] busy_q;

  assign poll_o    = (phase_q == PW'(PHASES - 1));
  assign poll_ok_o = poll_o && (busy_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (poll_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // polls swallowed while the hardware call runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else if (call_i) begin
      busy_q <= BW'(CALL_MC - 1);
    end else if (poll_o && busy_q != '0) begin
      busy_q <= busy_q - 1'b1;
    end
  end
endmodule

// File: rtl/intc_select.sv
module intc_select
  import intc_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  lvl_e            lvl_i [NSRC],
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o,
  output lvl_e            lvl_o
);
  logic [NSRC-1:0] by_lvl [NLVL];

  for (genvar gl = 0; gl < NLVL; gl++) begin : g_lvl
    for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
      assign by_lvl[gl][gs] = req_i[gs] && (lvl_i[gs] == lvl_e'(gl));
    end
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_LOW;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (!hit_o && |by_lvl[l]) begin
        hit_o = 1'b1;
        lvl_o = lvl_e'(l);
        for (int s = NSRC - 1; s >= 0; s--) begin
          if (by_lvl[l][s]) idx_o = IDXW'(s);
        end
      end
    end
  end
endmodule

// File: rtl/intc_svc.sv
module intc_svc
  import intc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  lvl_e            lvl_i,
  input  logic            pop_i,
  output logic            blk_o,
  output logic [NLVL-1:0] svc_o
);
  logic [NLVL-1:0] svc_q, pop_nxt;

  assign blk_o = |(svc_q >> int'(lvl_i));
  assign svc_o = svc_q;

  always_comb begin
    pop_nxt = svc_q;
    for (int l = 0; l < NLVL; l++) begin
      if (svc_q[l]) pop_nxt = svc_q & ~(NLVL'(1) << l);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q <= '0;
    end else if (set_i) begin
      svc_q[lvl_i] <= 1'b1;
    end else if (pop_i) begin
      svc_q <= pop_nxt;
    end
  end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
  import intc_pkg::*;
#(
  parameter int PHASES  = 4,
  parameter int CALL_MC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  req_i,
  input  logic        ser_tx_i,
  input  logic        t2_ext_i,
  input  logic [7:0]  en_i,
  input  logic        glb_en_i,
  input  logic [7:0]  hi_pri_i,
  input  logic [1:0]  ext_edge_i,
  input  logic        last_cyc_i,
  input  logic        reg_wr_i,
  input  logic        reti_i,
  output logic        call_o,
  output logic [7:0]  ack_o,
  output logic [15:0] vec_o,
  output logic [7:0]  clr_o,
  output logic [2:0]  in_svc_o
);
  logic [NSRC-1:0] raw, elig, clr_mask;
  lvl_e            lvl_of [NSRC];
  logic            hit, blocked, poll, poll_ok, go;
  logic [IDXW-1:0] win_idx;
  lvl_e            win_lvl;

  assign raw = req_i | {1'b0, t2_ext_i, ser_tx_i, 5'b0};

  for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
    if (gs == 0) begin : g_top
      assign lvl_of[gs] = LVL_TOP;
      assign elig[gs]   = raw[gs] && en_i[gs];
    end else begin : g_std
      assign lvl_of[gs] = hi_pri_i[gs] ? LVL_HIGH : LVL_LOW;
      assign elig[gs]   = raw[gs] && en_i[gs] && glb_en_i;
    end
  end

  // hardware clears timer 0/1 always, externals only in edge mode
  assign clr_mask = {3'b000, 1'b1, ext_edge_i[1], 1'b1, ext_edge_i[0], 1'b0};

  intc_phase #(.PHASES(PHASES), .CALL_MC(CALL_MC)) u_phase (
    .clk_i, .rst_ni, .call_i(go), .poll_o(poll), .poll_ok_o(poll_ok)
  );

  intc_select u_sel (
    .req_i(elig), .lvl_i(lvl_of), .hit_o(hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  intc_svc u_svc (
    .clk_i, .rst_ni, .set_i(go), .lvl_i(win_lvl), .pop_i(poll && reti_i),
    .blk_o(blocked), .svc_o(in_svc_o)
  );

  assign go = poll_ok && hit && !blocked && last_cyc_i && !reg_wr_i && !reti_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_o <= 1'b0;
      ack_o  <= '0;
      clr_o  <= '0;
      vec_o  <= '0;
    end else begin
      call_o <= go;
      ack_o  <= go ? (NSRC'(1) << win_idx) : '0;
      clr_o  <= go ? ((NSRC'(1) << win_idx) & clr_mask) : '0;
      if (go) vec_o <= vec_of(win_idx);
    end
  end
endmodule

// File: rtl/intc_prio_arb_chk.sv
module intc_prio_arb_chk #(
  parameter int PHASES  = 4,
  parameter int CALL_MC = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  req_i,
  input logic        ser_tx_i,
  input logic        t2_ext_i,
  input logic        glb_en_i,
  input logic        last_cyc_i,
  input logic        reg_wr_i,
  input logic        reti_i,
  input logic        call_o,
  input logic [7:0]  ack_o,
  input logic [15:0] vec_o,
  input logic [7:0]  clr_o,
  input logic [2:0]  in_svc_o
);
  localparam int GAP = CALL_MC * PHASES;
  localparam int GW  = $clog2(GAP) + 1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= GW'(GAP);
    else if (call_o)          gap_q <= '0;
    else if (gap_q < GW'(GAP)) gap_q <= gap_q + 1'b1;
  end

  AST_CALL_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |=> !call_o); // R2
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> $countones(ack_o) == 1); // R2
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_o |-> ack_o == 8'h00 && clr_o == 8'h00); // R2
  AST_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> $past(last_cyc_i) && !$past(reg_wr_i) && !$past(reti_i)); // R6
  AST_GLB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_o && !ack_o[0]) |-> $past(glb_en_i)); // R3
  AST_TOP_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o[0] |-> vec_o == 16'h0033); // R5
  AST_CLR_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o & ~(ack_o & 8'h1E)) == 8'h00); // R12
  AST_SVC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> in_svc_o != 3'b000); // R11
  AST_CALL_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> gap_q >= GW'(GAP - 1)); // R10
  AST_LIVE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> ($past(req_i) != 8'h00 || $past(ser_tx_i) || $past(t2_ext_i))); // R8
endmodule

bind intc_prio_arb intc_prio_arb_chk #(.PHASES(PHASES), .CALL_MC(CALL_MC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ser_tx_i(ser_tx_i),
  .t2_ext_i(t2_ext_i), .glb_en_i(glb_en_i), .last_cyc_i(last_cyc_i),
  .reg_wr_i(reg_wr_i), .reti_i(reti_i), .call_o(call_o), .ack_o(ack_o),
  .vec_o(vec_o), .clr_o(clr_o), .in_svc_o(in_svc_o)
);

// File: tb/sim_intc_prio_arb.sv
module sim_intc_prio_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0, en = 8'hFF, hi_pri = '0;
  logic        ser_tx = 1'b0, t2_ext = 1'b0, glb_en = 1'b1;
  logic [1:0]  ext_edge = 2'b11;
  logic        last_cyc = 1'b0, reg_wr = 1'b0, reti = 1'b0;
  logic        call_o;
  logic [7:0]  ack_o, clr_o;
  logic [15:0] vec_o;
  logic [2:0]  in_svc_o;

  int checks = 0, errors = 0, calls = 0, pcnt = 0;
  logic [15:0] l_vec = '0;
  logic [7:0]  l_ack = '0, l_clr = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_prio_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ser_tx_i(ser_tx), .t2_ext_i(t2_ext),
    .en_i(en), .glb_en_i(glb_en), .hi_pri_i(hi_pri), .ext_edge_i(ext_edge),
    .last_cyc_i(last_cyc), .reg_wr_i(reg_wr), .reti_i(reti),
    .call_o(call_o), .ack_o(ack_o), .vec_o(vec_o), .clr_o(clr_o), .in_svc_o(in_svc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: exp_vec = 16'h0033; 1: exp_vec = 16'h0003; 2: exp_vec = 16'h000B;
      3: exp_vec = 16'h0013; 4: exp_vec = 16'h001B; 5: exp_vec = 16'h0023;
      6: exp_vec = 16'h002B; default: exp_vec = 16'h0063;
    endcase
  endfunction

  always @(posedge clk) if (rst_n) pcnt++;

  always @(negedge clk) begin
    if (call_o) begin
      calls++;
      l_vec = vec_o; l_ack = ack_o; l_clr = clr_o;
      chk("R2 call on poll edge", pcnt % 4, 0);
    end
  end

  // one machine cycle window containing exactly one poll edge
  task automatic win(input bit lc, input bit wr, input bit rt);
    last_cyc = lc; reg_wr = wr; reti = rt;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic expect_call(input string tag, input int s);
    int c0 = calls;
    win(1, 0, 0);
    chk({tag, " call count"}, calls - c0, 1);
    chk({tag, " ack"}, l_ack, 8'(1) << s);
    chk({tag, " vector"}, l_vec, exp_vec(s));
  endtask

  task automatic expect_none(input string tag, input bit lc, input bit wr, input bit rt);
    int c0 = calls;
    win(lc, wr, rt);
    chk({tag, " no call"}, calls - c0, 0);
  endtask

  task automatic idle3;
    req = '0; ser_tx = 0; t2_ext = 0;
    repeat (3) win(1, 0, 0);
  endtask

  task automatic reti_win;
    req = '0; ser_tx = 0; t2_ext = 0;
    win(1, 0, 1);
  endtask

  task automatic cleanup;
    idle3; reti_win;
  endtask

  task automatic t_reset;
    chk("R1 call", call_o, 0); chk("R1 ack", ack_o, 0); chk("R1 clr", clr_o, 0);
    chk("R1 vec", vec_o, 0);   chk("R1 svc", in_svc_o, 0);
  endtask

  task automatic t_vectors_and_clear;
    for (int s = 0; s < 8; s++) begin
      req = 8'(1) << s;
      expect_call("R5", s);
      chk("R12 clear strobe", l_clr, (s >= 1 && s <= 4) ? (8'(1) << s) : 8'h00);
      cleanup;
      chk("R11 svc after return", in_svc_o, 0);
    end
    ext_edge = 2'b00; req = 8'h02;
    expect_call("R12 level ext0", 1);
    chk("R12 level ext0 not cleared", l_clr, 0);
    cleanup;
    req = 8'h08;
    expect_call("R12 level ext1", 3);
    chk("R12 level ext1 not cleared", l_clr, 0);
    cleanup;
    ext_edge = 2'b11;
  endtask

  task automatic t_order;
    req = 8'hFE; expect_call("R4 same level order", 1); cleanup;
    req = 8'hE0; expect_call("R4 same level order low", 5); cleanup;
    hi_pri = 8'h80; req = 8'h82; expect_call("R4 high beats index", 7);
    chk("R11 high level marked", in_svc_o, 3'b010); cleanup;
    hi_pri = 8'hFF; req = 8'hFF; expect_call("R4 top beats high", 0);
    chk("R11 top level marked", in_svc_o, 3'b100); cleanup;
    hi_pri = 8'h01; req = 8'h81; expect_call("R4 top fixed", 0); cleanup;
    hi_pri = 8'h00;
  endtask

  task automatic t_enables;
    glb_en = 0; req = 8'hFF; expect_call("R3 top ignores global", 0); cleanup;
    glb_en = 0; req = 8'hFE; expect_none("R3 global off", 1, 0, 0);
    glb_en = 1; en = 8'hFE; req = 8'h01; expect_none("R3 own enable off", 1, 0, 0);
    en = 8'hFB; req = 8'h04; expect_none("R3 source enable off", 1, 0, 0);
    en = 8'hFF; req = 8'h00;
  endtask

  task automatic t_gates;
    req = 8'h04;
    expect_none("R6 not last cycle", 0, 0, 0);
    expect_none("R6 enable write", 1, 1, 0);
    expect_none("R6 return", 1, 0, 1);
    expect_call("R6 all met", 2); cleanup;
  endtask

  task automatic t_no_memory;
    req = 8'h04; expect_none("R8 refused", 0, 0, 0);
    req = 8'h00; expect_none("R8 gone", 1, 0, 0);
  endtask

  task automatic t_or_sources;
    ser_tx = 1; expect_call("R9 serial tx", 5); cleanup;
    t2_ext = 1; expect_call("R9 timer2 ext", 6); cleanup;
  endtask

  task automatic t_nesting;
    req = 8'h04; expect_call("R7 low first", 2);
    chk("R11 low set", in_svc_o, 3'b001); idle3;
    req = 8'h10; expect_none("R7 equal low blocked", 1, 0, 0);
    hi_pri = 8'h08; req = 8'h08; expect_call("R7 high nests", 3);
    chk("R11 high set", in_svc_o, 3'b011); idle3;
    req = 8'h08; expect_none("R7 equal high blocked", 1, 0, 0);
    req = 8'h01; expect_call("R7 top nests", 0);
    chk("R11 all set", in_svc_o, 3'b111); idle3;
    reti_win; chk("R11 pop top", in_svc_o, 3'b011);
    reti_win; chk("R11 pop high", in_svc_o, 3'b001);
    reti_win; chk("R11 pop low", in_svc_o, 3'b000);
    hi_pri = 8'h00;
  endtask

  task automatic t_busy;
    req = 8'h04; expect_call("R10 first", 2);
    req = 8'h01;
    expect_none("R10 busy 1", 1, 0, 0);
    expect_none("R10 busy 2", 1, 0, 0);
    expect_none("R10 busy 3", 1, 0, 0);
    expect_call("R10 after call", 0);
    chk("R11 top over low", in_svc_o, 3'b101);
    idle3; reti_win; reti_win;
    chk("R11 cleared", in_svc_o, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    repeat (2) @(negedge clk);
    t_vectors_and_clear;
    t_order;
    t_enables;
    t_gates;
    t_no_memory;
    t_or_sources;
    t_nesting;
    t_busy;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule